// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Bank

This block turns pin transitions on one bank of general-purpose pins into a single bank interrupt. Each pin has a two-bit trigger selector taken from its control word. The selector picks rising edges, falling edges, both edges or no detection. A detected edge sets a sticky status bit. The bank interrupt is raised while any status bit is set whose pin is not masked. Level triggering is not offered.

Software reaches the block over a simple 32-bit register bus with three words:
- a status word, where writing ones clears bits;
- a mask-set port, where writing ones masks pins;
- a mask-clear port, where writing ones unmasks pins.

Both mask ports read back the current mask. Writes only take effect while the write-enable input is high; it stands in for the bank's write lock. The pin inputs are expected to be synchronised already.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the status word reads 0, the mask reads all ones (every pin masked) and `irq_o` is low.
- R2: A pin whose trigger selector (control word bits 4:3, here `edge_cfg[2*i+1:2*i]`) is 1 sets its status bit on a 0-to-1 transition and not on a 1-to-0 transition.
- R3: A selector of 2 sets the status bit on a 1-to-0 transition only.
- R4: A selector of 3 sets the status bit on either transition.
- R5: A selector of 0 never sets the status bit.
- R6: Writing the status word (offset 0x080 + 4*BANK_ID) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R7: Writing 1s to the mask-set port (offset 0x0A0 + 4*BANK_ID) masks those pins, and writing 1s to the mask-clear port (offset 0x0C0 + 4*BANK_ID) unmasks them. A read of either port returns the current mask, where bit i = 1 means pin i is masked.
- R8: `irq_o` is high exactly while some status bit is set with its mask bit clear.
- R9: Status bits latch while their pin is masked; unmasking such a pin raises `irq_o`.
- R10: An edge in the same cycle as a status write that clears its bit leaves that bit set.
- R11: While `wr_allow` is low, bus writes change neither the status word nor the mask.
- R12: A pin already high when reset is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPIN | Synchronised pin levels |
| edge_cfg | input | 2*NPIN | Trigger selector per pin, two bits each |
| wr_allow | input | 1 | Write enable for the bank's registers |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data, combinational; 0 when not reading a decoded word |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
The bench sets the four trigger groups and toggles every pin in both directions, so a selector decoded with swapped bits would set the falling group on rising edges. It aims a status clear at the same cycle as fresh edges on those bits. A design that lets the clear win would drop the event and read back zero. It holds pins high through reset to catch a spurious rising edge on the first cycle. It also tries writes with `wr_allow` low, and clears single status bits and mask bits, so that masking applied after the interrupt logic, or a write-to-clear that also touches zero bits, shows up as a wrong readback or a wrong `irq_o`.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  localparam int unsigned OFS_STATUS   = 32'h080;
  localparam int unsigned OFS_MASK_SET = 32'h0A0;
  localparam int unsigned OFS_MASK_CLR = 32'h0C0;

  function automatic int unsigned word_addr(int unsigned base, int unsigned bank);
    return base + 4 * bank;
  endfunction

endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_i,
  input  logic [2*NPIN-1:0] cfg_i,
  output logic [NPIN-1:0]   hit_o
);
  import gpio_irq_pkg::*;

  logic [NPIN-1:0] prev_q, prev_d;
  logic            armed_q, armed_d;
  logic [NPIN-1:0] rise, fall;

  always_comb begin
    prev_d  = pin_i;
    armed_d = 1'b1;
    rise    = pin_i & ~prev_q;
    fall    = ~pin_i & prev_q;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    trig_e sel;
    assign sel = trig_e'(cfg_i[2*i +: 2]);
    always_comb begin
      unique case (sel)
        TRIG_RISE: hit_o[i] = armed_q & rise[i];
        TRIG_FALL: hit_o[i] = armed_q & fall[i];
        TRIG_BOTH: hit_o[i] = armed_q & (rise[i] | fall[i]);
        default:   hit_o[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
    end
  end

endmodule

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode #(
  parameter int AW      = 12,
  parameter int BANK_ID = 0
) (
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic          wr_allow,
  output logic          hit_stat,
  output logic          hit_mset,
  output logic          hit_mclr,
  output logic          wr_stat,
  output logic          wr_mset,
  output logic          wr_mclr
);
  import gpio_irq_pkg::*;

  localparam logic [AW-1:0] A_STAT = AW'(word_addr(OFS_STATUS,   BANK_ID));
  localparam logic [AW-1:0] A_MSET = AW'(word_addr(OFS_MASK_SET, BANK_ID));
  localparam logic [AW-1:0] A_MCLR = AW'(word_addr(OFS_MASK_CLR, BANK_ID));

  logic wr_go;

  always_comb begin
    hit_stat = bus_sel && (bus_addr == A_STAT);
    hit_mset = bus_sel && (bus_addr == A_MSET);
    hit_mclr = bus_sel && (bus_addr == A_MCLR);
    wr_go    = bus_we && wr_allow;
    wr_stat  = hit_stat && wr_go;
    wr_mset  = hit_mset && wr_go;
    wr_mclr  = hit_mclr && wr_go;
  end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] hit_i,
  input  logic            wr_stat,
  input  logic            wr_mset,
  input  logic            wr_mclr,
  input  logic [NPIN-1:0] wdata,
  output logic [NPIN-1:0] stat_q,
  output logic [NPIN-1:0] mask_q
);

  logic [NPIN-1:0] stat_d, mask_d, clr_vec;
  logic            stat_en, mask_en;

  always_comb begin
    clr_vec = wr_stat ? wdata : '0;
    stat_en = wr_stat || (|hit_i);
    stat_d  = (stat_q & ~clr_vec) | hit_i;
    mask_en = wr_mset || wr_mclr;
    mask_d  = mask_q;
    if (wr_mset) mask_d = mask_d | wdata;
    if (wr_mclr) mask_d = mask_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPIN    = 32,
  parameter int AW      = 12,
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_in,
  input  logic [2*NPIN-1:0] edge_cfg,
  input  logic              wr_allow,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  output logic              irq_o
);

  logic [NPIN-1:0] hit, stat_q, mask_q;
  logic hit_stat, hit_mset, hit_mclr, wr_stat, wr_mset, wr_mclr;

  gpio_edge_detect #(.NPIN(NPIN)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_in),
    .cfg_i (edge_cfg),
    .hit_o (hit)
  );

  gpio_irq_decode #(.AW(AW), .BANK_ID(BANK_ID)) u_dec (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wr_allow (wr_allow),
    .hit_stat (hit_stat),
    .hit_mset (hit_mset),
    .hit_mclr (hit_mclr),
    .wr_stat  (wr_stat),
    .wr_mset  (wr_mset),
    .wr_mclr  (wr_mclr)
  );

  gpio_irq_regs #(.NPIN(NPIN)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .wr_stat (wr_stat),
    .wr_mset (wr_mset),
    .wr_mclr (wr_mclr),
    .wdata   (bus_wdata),
    .stat_q  (stat_q),
    .mask_q  (mask_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (!bus_we) begin
      if (hit_stat)                 bus_rdata = stat_q;
      else if (hit_mset || hit_mclr) bus_rdata = mask_q;
    end
    irq_o = |(stat_q & ~mask_q);
  end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPIN    = 32,
  parameter int AW      = 12,
  parameter int BANK_ID = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*NPIN-1:0] edge_cfg,
  input logic              wr_allow,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   hit,
  input logic [NPIN-1:0]   stat_q,
  input logic [NPIN-1:0]   mask_q
);
  import gpio_irq_pkg::*;

  localparam logic [AW-1:0] C_STAT = AW'(word_addr(OFS_STATUS,   BANK_ID));
  localparam logic [AW-1:0] C_MSET = AW'(word_addr(OFS_MASK_SET, BANK_ID));

  logic [NPIN-1:0] cfg_any, clr_req, set_req;
  logic            wr_ok;

  always_comb begin
    for (int i = 0; i < NPIN; i++) cfg_any[i] = |edge_cfg[2*i +: 2];
    wr_ok   = bus_sel && bus_we && wr_allow;
    clr_req = (wr_ok && bus_addr == C_STAT) ? bus_wdata : '0;
    set_req = (wr_ok && bus_addr == C_MSET) ? bus_wdata : '0;
  end

  // R5
  no_hit_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & ~cfg_any) == '0));

  // R6
  stat_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~stat_q) & ~$past(clr_req)) == '0));

  // R10
  edge_always_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(hit) & ~stat_q) == '0));

  // R7
  mask_rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((~$past(mask_q) & mask_q) & ~$past(set_req)) == '0));

  // R11
  mask_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow |=> $stable(mask_q));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPIN(NPIN), .AW(AW), .BANK_ID(BANK_ID)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .edge_cfg  (edge_cfg),
  .wr_allow  (wr_allow),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .hit       (hit),
  .stat_q    (stat_q),
  .mask_q    (mask_q)
);

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
  localparam int NPIN = 32;
  localparam int AW   = 12;
  localparam logic [AW-1:0] A_STAT = 12'h080;
  localparam logic [AW-1:0] A_MSET = 12'h0A0;
  localparam logic [AW-1:0] A_MCLR = 12'h0C0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NPIN-1:0]   pin_in;
  logic [2*NPIN-1:0] edge_cfg;
  logic              wr_allow, bus_sel, bus_we;
  logic [AW-1:0]     bus_addr;
  logic [NPIN-1:0]   bus_wdata, bus_rdata;
  logic              irq_o;

  int    checks = 0, failures = 0;
  bit    done = 1'b0;
  item_t sb_q[$];

  always #5 clk = ~clk;

  gpio_irq_bank #(.NPIN(NPIN), .AW(AW), .BANK_ID(0)) i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .edge_cfg(edge_cfg),
    .wr_allow(wr_allow), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  // monitor: compares queued expectations shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk); #3;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? 32'(irq_o) : bus_rdata;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic chk_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #5;
    bus_sel = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = 32'(e); it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #5;
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d, input logic en);
    @(negedge clk);
    wr_allow = en; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0; wr_allow = 1'b1;
  endtask

  task automatic drive_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    @(posedge clk); #1;
  endtask

  task automatic pins_with_clear(input logic [31:0] v, input logic [31:0] clr);
    @(negedge clk);
    pin_in = v; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_STAT; bus_wdata = clr;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // groups: pins 0-7 rise(1), 8-15 fall(2), 16-23 both(3), 24-31 off(0)
    for (int i = 0; i < NPIN; i++)
      edge_cfg[2*i +: 2] = (i < 8) ? 2'd1 : (i < 16) ? 2'd2 : (i < 24) ? 2'd3 : 2'd0;
    rst_n = 1'b0; pin_in = 32'hFFFF_0000; wr_allow = 1'b1;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    chk_rd(A_STAT, 32'h0, "R1 R12 status after reset");
    chk_rd(A_MSET, 32'hFFFF_FFFF, "R1 mask after reset");
    chk_irq(1'b0, "R1 irq after reset");

    drive_pins(32'h0000_FFFF);
    chk_rd(A_STAT, 32'h00FF_00FF, "R2 R4 R5 rise of 0-15, fall of 16-31");
    chk_irq(1'b0, "R9 masked pins give no irq");

    bus_wr(A_STAT, 32'hFFFF_FFFF, 1'b1);
    chk_rd(A_STAT, 32'h0, "R6 clear all");

    drive_pins(32'hFFFF_0000);
    chk_rd(A_STAT, 32'h00FF_FF00, "R3 R4 fall of 0-15, rise of 16-31");

    bus_wr(A_STAT, 32'h0000_F000, 1'b1);
    chk_rd(A_STAT, 32'h00FF_0F00, "R6 partial clear keeps zero-written bits");

    bus_wr(A_MCLR, 32'h0000_0100, 1'b1);
    chk_rd(A_MSET, 32'hFFFF_FEFF, "R7 mask via set port");
    chk_rd(A_MCLR, 32'hFFFF_FEFF, "R7 mask via clear port");
    chk_irq(1'b1, "R8 R9 unmasked latched bit raises irq");

    bus_wr(A_STAT, 32'h0000_0100, 1'b1);
    chk_irq(1'b0, "R8 irq drops after clear");

    bus_wr(A_MSET, 32'h0000_0100, 1'b1);
    chk_rd(A_MCLR, 32'hFFFF_FFFF, "R7 mask set port");
    bus_wr(A_MCLR, 32'h0001_0000, 1'b1);
    chk_irq(1'b1, "R8 second unmask");

    bus_wr(A_STAT, 32'hFFFF_FFFF, 1'b0);
    chk_rd(A_STAT, 32'h00FF_0E00, "R11 locked status write ignored");
    bus_wr(A_MCLR, 32'hFFFF_FFFF, 1'b0);
    chk_rd(A_MSET, 32'hFFFE_FFFF, "R11 locked mask write ignored");

    bus_wr(A_STAT, 32'hFFFF_FFFF, 1'b1);
    chk_rd(A_STAT, 32'h0, "R6 clear before collision");
    pins_with_clear(32'h0000_FFFF, 32'h00FF_00FF);
    chk_rd(A_STAT, 32'h00FF_00FF, "R10 edge wins over clear");
    chk_irq(1'b1, "R10 irq from surviving bit");

    bus_wr(A_STAT, 32'hFFFF_FFFF, 1'b1);
    chk_irq(1'b0, "R8 all cleared");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule